// File: doc/BRIEF.md
# Keyed Software Watchdog

This block watches over software running on the chip. Once its enable input is high it counts time derived from the block clock. If software does not restart it in time, the block raises a timeout action. To restart it, software must perform a two-step key exchange on the register-write bus. First it writes 0x55 to the service address. At any later point it writes 0xAA to the same address. Any amount of unrelated bus traffic may fall between the two writes.

Time is measured by a binary divider chain that advances on a watchdog tick. The tick is either every block clock or one clock in every 2^PRE_LOG2 clocks, chosen by a prescale select. A 2-bit tap select picks how many low stages of the chain must fill before expiry. On expiry the action select chooses between two outputs. One is a one-cycle system reset request. The other is a highest-priority interrupt request that stays high until it is acknowledged. A hold input, driven by a debug-freeze or low-power-stop condition, stops the count.

The write bus, the enable and the configuration are plain control pins with no handshake. A write is taken in every cycle in which `bus_wr` is high, so the block never back-pressures the bus.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, `rst_req` and `irq_req` are both low.
- R2: With `pre_sel`=0 and `wd_enable` high, expiry happens on the 2^N-th counting clock edge after counting starts, with N = CHAIN_W-6+2*`tap_sel` (tap 0..3 gives N = 9, 11, 13, 15 at the default CHAIN_W=15). The action output is seen after that edge.
- R3: With `pre_sel`=1 the interval is 2^PRE_LOG2 times the R2 interval.
- R4: While `wd_enable` is low the block never raises an action, and the chain and prescaler are held at zero. A later enable therefore starts a full interval.
- R5: A write of 0xAA to SVC_ADDR after an earlier write of 0x55 to SVC_ADDR restarts the full interval from the edge of the 0xAA write, and uses up the key.
- R6: Writes to other addresses, and writes of values other than 0x55 or 0xAA to SVC_ADDR, placed between the two key writes, do not break the sequence.
- R7: A 0xAA write to SVC_ADDR without a preceding 0x55 has no effect on the interval. A repeated 0x55 keeps the key armed.
- R8: With `act_sel`=0, expiry produces a `rst_req` pulse exactly one cycle wide and no interrupt.
- R9: With `act_sel`=1, expiry sets `irq_req`, which stays high until a cycle with `irq_ack` high clears it. No reset pulse is produced.
- R10: While `wd_hold` is high the count does not advance. After release, the interval resumes from where it stopped.
- R11: After expiry the chain restarts by itself, so an unserviced watchdog fires again one full interval later.
- R12: A key completion on the same edge as an expiry suppresses that expiry and restarts the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data |
| wd_enable | input | 1 | Arms the watchdog |
| pre_sel | input | 1 | 1 selects the 2^PRE_LOG2 prescaler |
| tap_sel | input | 2 | Divider tap select for the interval |
| act_sel | input | 1 | 0 = reset request, 1 = interrupt request |
| wd_hold | input | 1 | Freeze / stop: holds the count |
| irq_ack | input | 1 | Clears a pending interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| irq_req | output | 1 | Level interrupt request, held until acknowledged |

## Verification
The checker relies on `act_sel`, `pre_sel` and `tap_sel` being changed only while `wd_enable` is low. It also relies on `irq_ack` being raised only while an interrupt is pending. The stimulus reconfigures only after dropping the enable for a cycle, and pulses the acknowledge only after it has seen `irq_req` high. Under these conditions the checker can tie each output edge to the action select and to the disable and hold conditions of the previous cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam int unsigned TAP_COUNT = 4;

  typedef enum logic {
    ACT_RESET = 1'b0,
    ACT_IRQ   = 1'b1
  } wd_action_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned PRE_LOG2 = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  logic [PRE_LOG2-1:0] cnt_q;

  assign tick = run & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
  parameter int unsigned CHAIN_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  input  logic [1:0] tap_sel,
  output logic       expire
);
  import wdog_pkg::*;

  logic [CHAIN_W-1:0]   stage_q;
  logic [TAP_COUNT-1:0] full;

  // Tap t watches the low CHAIN_W-6+2t stages.
  for (genvar g = 0; g < TAP_COUNT; g++) begin : g_tap
    localparam int unsigned WIDTH = CHAIN_W - 6 + 2 * g;
    localparam logic [CHAIN_W-1:0] MASK = {CHAIN_W{1'b1}} >> (CHAIN_W - WIDTH);
    assign full[g] = &(stage_q | ~MASK);
  end

  assign expire = tick & full[tap_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stage_q <= '0;
    else if (clr|expire) stage_q <= '0;
    else if (tick)       stage_q <= stage_q + 1'b1;
  end
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq #(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              restart
);
  import wdog_pkg::*;

  logic armed_q;
  logic hit;

  assign hit     = wr & (addr == SVC_ADDR);
  assign restart = hit & (wdata == KEY_FIRE) & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        armed_q <= 1'b0;
    else if (!enable || restart)       armed_q <= 1'b0;
    else if (hit && wdata == KEY_ARM)  armed_q <= 1'b1;
  end
endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic act_sel,
  input  logic irq_ack,
  output logic rst_req,
  output logic irq_req
);
  import wdog_pkg::*;

  wd_action_e act;
  assign act = wd_action_e'(act_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      rst_req <= fire & (act == ACT_RESET);
      if (fire && act == ACT_IRQ) irq_req <= 1'b1;
      else if (irq_ack)           irq_req <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 4'h7,
  parameter int unsigned PRE_LOG2 = 9,
  parameter int unsigned CHAIN_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              wd_enable,
  input  logic              pre_sel,
  input  logic [1:0]        tap_sel,
  input  logic              act_sel,
  input  logic              wd_hold,
  input  logic              irq_ack,
  output logic              rst_req,
  output logic              irq_req
);
  logic run, svc_restart, clr, pre_tick, wd_tick, expire, fire;

  assign run     = wd_enable & ~wd_hold;
  assign clr     = svc_restart | ~wd_enable;
  assign wd_tick = run & (pre_sel ? pre_tick : 1'b1);
  assign fire    = expire & ~svc_restart;

  wdog_keyseq #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_key (
    .clk(clk), .rst_n(rst_n), .enable(wd_enable), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .restart(svc_restart)
  );

  wdog_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .tick(pre_tick)
  );

  wdog_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .tick(wd_tick), .clr(clr),
    .tap_sel(tap_sel), .expire(expire)
  );

  wdog_action u_act (
    .clk(clk), .rst_n(rst_n), .fire(fire), .act_sel(act_sel),
    .irq_ack(irq_ack), .rst_req(rst_req), .irq_req(irq_req)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk (
  input logic clk,
  input logic rst_n,
  input logic wd_enable,
  input logic wd_hold,
  input logic act_sel,
  input logic irq_ack,
  input logic svc_restart,
  input logic rst_req,
  input logic irq_req
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8
  AST_RST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(act_sel)); // R8
  AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(act_sel)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req); // R9
  AST_IRQ_CLEAR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |-> $past(irq_ack)); // R9
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |=> (!rst_req && !$rose(irq_req))); // R4
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hold |=> (!rst_req && !$rose(irq_req))); // R10
  AST_KEY_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    svc_restart |=> (!rst_req && !$rose(irq_req))); // R12
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .wd_hold(wd_hold),
  .act_sel(act_sel), .irq_ack(irq_ack), .svc_restart(svc_restart),
  .rst_req(rst_req), .irq_req(irq_req)
);

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
  localparam int CW = 7;
  localparam int PL = 2;
  localparam int AW = 4;
  localparam logic [AW-1:0] SA = 4'h7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, bus_wr = 1'b0, wd_enable = 1'b0, pre_sel = 1'b0;
  logic act_sel = 1'b0, wd_hold = 1'b0, irq_ack = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [1:0] tap_sel = '0;
  logic rst_req, irq_req;

  int cyc = 0;
  int checks = 0, fails = 0;
  always @(posedge clk) cyc++;

  wdog_keyed #(.ADDR_W(AW), .SVC_ADDR(SA), .PRE_LOG2(PL), .CHAIN_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wd_enable(wd_enable), .pre_sel(pre_sel),
    .tap_sel(tap_sel), .act_sel(act_sel), .wd_hold(wd_hold),
    .irq_ack(irq_ack), .rst_req(rst_req), .irq_req(irq_req)
  );

  function automatic int period(int t, int p);
    return (1 << (CW - 6 + 2 * t)) * (p != 0 ? (1 << PL) : 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiesce();
    @(negedge clk);
    wd_enable = 1'b0; wd_hold = 1'b0; irq_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic start(input int t, input bit p, input bit a, output int e0);
    @(negedge clk);
    tap_sel = t[1:0]; pre_sel = p; act_sel = a; wd_enable = 1'b1;
    e0 = cyc;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    e = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_rst(input int lim, output int e);
    e = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rst_req) begin e = cyc; break; end
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int e0, e, b, f1, tmp;
    repeat (3) @(negedge clk);
    chk(!rst_req && !irq_req, "R1 reset state", {rst_req, irq_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rst_req && !irq_req, "R1 after release", {rst_req, irq_req}, 0);

    // R2/R3/R8/R11: sweep every tap and prescale setting in reset mode
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 2; p++) begin
        quiesce();
        start(t, p[0], 1'b0, e0);
        wait_rst(period(t, p) + 20, f1);
        chk(f1 == e0 + period(t, p), p ? "R3 prescaled interval" : "R2 tap interval",
            f1 - e0, period(t, p));
        chk(irq_req == 1'b0, "R8 no interrupt in reset mode", irq_req, 0);
        @(negedge clk);
        chk(rst_req == 1'b0, "R8 pulse one cycle", rst_req, 0);
        wait_rst(period(t, p) + 20, e);
        chk(e == f1 + period(t, p), "R11 automatic re-arm", e - f1, period(t, p));
      end
    end

    // R9: interrupt mode, held until acknowledged
    quiesce();
    start(3, 1'b0, 1'b1, e0);
    e = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      chk(!rst_req, "R9 no reset pulse in interrupt mode", rst_req, 0);
      if (irq_req) begin e = cyc; break; end
    end
    chk(e == e0 + period(3, 0), "R9 interrupt timing", e - e0, period(3, 0));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(irq_req, "R9 interrupt held", irq_req, 1);
    end
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(!irq_req, "R9 cleared by ack", irq_req, 0);

    // R4: disabled never fires, and re-enable gives a full interval
    @(negedge clk);
    wd_enable = 1'b0; act_sel = 1'b0; tap_sel = 2'd0; pre_sel = 1'b0;
    tmp = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rst_req || irq_req) tmp++;
    end
    chk(tmp == 0, "R4 disabled stays quiet", tmp, 0);
    start(1, 1'b0, 1'b0, e0);
    wait_rst(100, e);
    chk(e == e0 + period(1, 0), "R4 full interval after enable", e - e0, period(1, 0));

    // R10: hold freezes the count
    quiesce();
    start(1, 1'b0, 1'b0, e0);
    repeat (3) @(negedge clk);
    wd_hold = 1'b1;
    tmp = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rst_req) tmp++;
    end
    chk(tmp == 0, "R10 no expiry while held", tmp, 0);
    wd_hold = 1'b0;
    wait_rst(100, e);
    chk(e == e0 + 28, "R10 resumes where stopped", e - e0, 28);

    // R5/R6: key with intervening traffic restarts the interval
    quiesce();
    start(2, 1'b0, 1'b0, e0);
    wr(SA, 8'h55, tmp);
    wr(4'h3, 8'hAA, tmp);
    wr(SA, 8'h12, tmp);
    wr(SA, 8'hAA, b);
    wait_rst(200, e);
    chk(e == b + period(2, 0), "R5 R6 restart from key edge", e - b, period(2, 0));

    // R7: lone 0xAA has no effect
    quiesce();
    start(2, 1'b0, 1'b0, e0);
    wr(SA, 8'hAA, tmp);
    wait_rst(200, e);
    chk(e == e0 + period(2, 0), "R7 lone AA ignored", e - e0, period(2, 0));

    // R7: repeated 0x55 keeps the key armed
    quiesce();
    start(2, 1'b0, 1'b0, e0);
    wr(SA, 8'h55, tmp);
    wr(SA, 8'h55, tmp);
    wr(SA, 8'hAA, b);
    wait_rst(200, e);
    chk(e == b + period(2, 0), "R7 double 55 stays armed", e - b, period(2, 0));

    // R12: key completes on the expiry edge
    quiesce();
    start(1, 1'b0, 1'b0, e0);
    wr(SA, 8'h55, tmp);
    repeat (4) @(negedge clk);
    wr(SA, 8'hAA, b);
    chk(b == e0 + period(1, 0), "R12 schedule", b - e0, period(1, 0));
    wait_rst(100, e);
    chk(e == b + period(1, 0), "R12 key beats expiry", e - b, period(1, 0));

    quiesce();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule